// File: doc/BRIEF.md
# Video Field Temporal Decimator

The block sits in an interlaced pixel stream and lowers its field rate by withholding whole fields. Every beat carries pixel data, a field-start flag that marks the first beat of a field, and a parity flag that tells odd fields from even ones. For each field the block either forwards all of its beats or discards all of them. It makes that choice on the field's first beat, from the configuration in force at that moment.

The configuration byte selects one of four modes. Two modes are frame-based: a frame is a pair of fields and begins on the even field in one mode and on the odd field in the other. In these modes both fields of a frame share one outcome. The other two modes are parity-based. One drops only even fields and the other drops only odd fields. A rate value N means that N units (frames or fields of the selected parity) are skipped, then one is forwarded, and the pattern repeats.

Both stream sides use valid/ready. Beats of a field that is forwarded pass through without change: output valid follows input valid and input ready follows output ready. Beats of a field that is discarded are taken at once with input ready high and output valid low, so back-pressure from the sink cannot stall a dropped field. The configuration port is a plain write strobe with a data byte.

Top module: `field_decimator`

## Requirements
- R1: After reset the enable bit, mode, rate and skip counter are all zero, so every field is forwarded and output valid is low while input valid is low.
- R2: While the enable bit is 0, every field is forwarded whatever the mode and rate hold.
- R3: Mode 00 drops whole frames, where a frame is an even field followed by an odd field. Both fields of a frame get the same outcome, and the frame counts once toward the skip count.
- R4: Mode 01 behaves as mode 00, except that a frame is an odd field followed by an even field.
- R5: Mode 10 subjects only even fields (parity flag 0) to the skip count. Odd fields are always forwarded.
- R6: Mode 11 subjects only odd fields (parity flag 1) to the skip count. Even fields are always forwarded.
- R7: With rate N (0 to 15), after N units have been skipped the next unit is forwarded and the counter returns to zero. Rate 0 forwards every unit.
- R8: The forward/drop choice is fixed on the accepted field-start beat and holds for every beat up to the next field start, even if the configuration is written during the field.
- R9: Configuration byte layout: bit 0 enable, bits 2:1 mode, bits 6:3 rate, and bit 7 reserved. Bit 7 has no effect. A write takes effect at the next accepted field start.
- R10: When a field start is accepted with the enable bit newly set (it was 0 at the previous field start), the skip counter starts from zero.
- R11: On a forwarded field, out_valid equals in_valid, in_ready equals out_ready, and data, field-start and parity are copied unchanged. On a dropped field, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DATA_W | Input pixel data |
| in_sof | input | 1 | First beat of a field |
| in_odd | input | 1 | Field parity, 1 = odd |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink ready |
| out_data | output | DATA_W | Output pixel data |
| out_sof | output | 1 | First beat of a forwarded field |
| out_odd | output | 1 | Parity of the forwarded field |

## Verification
The bench builds the block with its default parameters: 8-bit pixels and a 4-bit rate. With these values the full range of rates, 0 to 15, can be reached within a short run, including the largest skip of 15 frames. Short fields of one to five beats keep the runs short enough to cover many field starts, mode switches and enable toggles. Random sink stalls together with occasional repeated parities test the gating under back-pressure and on streams that do not alternate.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
  localparam int unsigned FDEC_RATE_W = 4;

  typedef enum logic [1:0] {
    FRM_EVEN  = 2'b00,
    FRM_ODD   = 2'b01,
    DROP_EVEN = 2'b10,
    DROP_ODD  = 2'b11
  } fdec_mode_e;
endpackage

// File: rtl/field_decim_cfg.sv
module field_decim_cfg
  import fdec_pkg::*;
#(
  parameter int unsigned RATE_W = FDEC_RATE_W,
  localparam int unsigned CFG_W = RATE_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_W-1:0]  wdata,
  output logic              en,
  output fdec_mode_e        mode,
  output logic [RATE_W-1:0] rate
);
  // the top bit is reserved and is never stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mode <= FRM_EVEN;
      rate <= '0;
    end else if (we) begin
      en   <= wdata[0];
      mode <= fdec_mode_e'(wdata[2:1]);
      rate <= wdata[3 +: RATE_W];
    end
  end
endmodule

// File: rtl/field_decim_sched.sv
module field_decim_sched
  import fdec_pkg::*;
#(
  parameter int unsigned RATE_W = FDEC_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_now,
  input  logic              sof_acc,
  input  logic              odd,
  input  logic              cfg_en,
  input  fdec_mode_e        cfg_mode,
  input  logic [RATE_W-1:0] cfg_rate,
  output logic              pass_now
);
  logic              en_q, fp_q, pass_q;
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] base, cnt_n;
  logic              fp_base, hit, dec_pass, fp_n;

  always_comb begin
    base     = en_q ? cnt_q : '0;
    fp_base  = en_q ? fp_q : 1'b1;
    hit      = (base >= cfg_rate);
    dec_pass = 1'b1;
    cnt_n    = base;
    fp_n     = fp_base;
    if (!cfg_en) begin
      cnt_n = '0;
      fp_n  = 1'b1;
    end else if (!cfg_mode[1]) begin
      // frame modes: mode bit 0 gives the parity that opens a frame
      if (odd == cfg_mode[0]) begin
        dec_pass = hit;
        cnt_n    = hit ? '0 : base + 1'b1;
        fp_n     = hit;
      end else begin
        dec_pass = fp_base;
      end
    end else begin
      // parity modes: mode bit 0 gives the parity being thinned
      if (odd == cfg_mode[0]) begin
        dec_pass = hit;
        cnt_n    = hit ? '0 : base + 1'b1;
      end
    end
  end

  assign pass_now = sof_now ? dec_pass : pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      fp_q   <= 1'b1;
      pass_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sof_acc) begin
      en_q   <= cfg_en;
      fp_q   <= fp_n;
      pass_q <= dec_pass;
      cnt_q  <= cnt_n;
    end
  end

  // R2
  dis_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_now && !cfg_en |-> pass_now);
  // R5
  keep_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_now && cfg_en && cfg_mode == DROP_EVEN && odd |-> pass_now);
  // R6
  keep_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_now && cfg_en && cfg_mode == DROP_ODD && !odd |-> pass_now);
  // R7
  rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_now && cfg_en && cfg_rate == '0 && (cfg_mode[1] || odd == cfg_mode[0])
    |-> pass_now);
  // R8
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_acc |=> pass_q == $past(pass_q));
  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_acc && cfg_en && !en_q |=> cnt_q <= 1);
endmodule

// File: rtl/field_decim_gate.sv
module field_decim_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_odd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_odd
);
  assign out_valid = in_valid & pass;
  assign in_ready  = pass ? out_ready : 1'b1;
  assign out_data  = in_data;
  assign out_sof   = in_sof;
  assign out_odd   = in_odd;

  // R11
  drop_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !out_valid |-> in_ready);
  // R11
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);
endmodule

// File: rtl/field_decimator.sv
module field_decimator
  import fdec_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RATE_W = FDEC_RATE_W,
  localparam int unsigned CFG_W = RATE_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_odd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_odd
);
  logic              c_en;
  fdec_mode_e        c_mode;
  logic [RATE_W-1:0] c_rate;
  logic              pass, sof_now, sof_acc;

  assign sof_now = in_valid & in_sof;
  assign sof_acc = sof_now & in_ready;

  field_decim_cfg #(.RATE_W(RATE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .en(c_en), .mode(c_mode), .rate(c_rate)
  );

  field_decim_sched #(.RATE_W(RATE_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .sof_now(sof_now), .sof_acc(sof_acc),
    .odd(in_odd), .cfg_en(c_en), .cfg_mode(c_mode), .cfg_rate(c_rate),
    .pass_now(pass)
  );

  field_decim_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .pass(pass),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_odd(in_odd),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_odd(out_odd)
  );
endmodule

// File: tb/field_decimator_test.sv
`timescale 1ns/1ps
module field_decimator_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_odd = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, out_valid, out_sof, out_odd;
  logic [7:0] out_data;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference state built from the requirements
  bit       p_en = 0;  bit [1:0] p_mode = 0;  bit [3:0] p_rate = 0;
  bit       m_en = 0;  bit       m_fp = 1;    bit [3:0] m_cnt = 0;

  field_decimator uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_odd(in_odd), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .out_odd(out_odd)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic bit [7:0] mk(bit en, bit [1:0] mode, bit [3:0] rate);
    return {1'b0, rate, mode, en};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R7 R3 R4 R5 R6 R10: outcome of a field start from the pending config
  task automatic model_sof(input bit odd, output bit pass);
    bit [3:0] b; bit fb; bit hit;
    b = m_en ? m_cnt : 4'd0;
    fb = m_en ? m_fp : 1'b1;
    hit = (b >= p_rate);
    pass = 1;
    if (!p_en) begin
      m_cnt = 0; fb = 1;
    end else if (odd == p_mode[0]) begin
      pass = hit;
      m_cnt = hit ? 4'd0 : b + 4'd1;
      if (!p_mode[1]) fb = hit;
    end else begin
      m_cnt = b;
      if (!p_mode[1]) pass = fb;
    end
    m_fp = fb;
    m_en = p_en;
  endtask

  task automatic write_cfg(bit [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    p_en = v[0]; p_mode = v[2:1]; p_rate = v[6:3];
  endtask

  // one field; mid_we writes cfg during the field (R8)
  task automatic send_field(bit odd, int npix, int rdy_pct, string tag,
                            bit mid_we = 0, bit [7:0] mid_v = 0);
    bit exp_pass; int outs = 0; int errs = 0; int i = 0; bit wrote = 0;
    model_sof(odd, exp_pass);
    while (i < npix) begin
      @(negedge clk);
      cfg_we = 0;
      in_valid = 1; in_sof = (i == 0); in_odd = odd;
      in_data = 8'($urandom);
      out_ready = ($urandom % 100) < rdy_pct;
      if (mid_we && !wrote && i == npix / 2 && i > 0) begin
        cfg_we = 1; cfg_wdata = mid_v; wrote = 1;
        p_en = mid_v[0]; p_mode = mid_v[2:1]; p_rate = mid_v[6:3];
      end
      #3;
      if (exp_pass) begin
        if (!(out_valid && in_ready == out_ready && out_data == in_data &&
              out_sof == (i == 0) && out_odd == odd)) errs++;
      end else if (!(!out_valid && in_ready)) errs++;
      if (out_valid && out_ready) outs++;
      if (in_ready) i++;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; cfg_we = 0;
    check(errs == 0 && outs == (exp_pass ? npix : 0), tag,
          outs, exp_pass ? npix : 0);
  endtask

  task automatic run(int n, bit start_odd, string tag);
    for (int k = 0; k < n; k++) send_field(start_odd ^ k[0], 3, 70, tag);
  endtask

  initial begin
    bit par;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    #3;
    check(out_valid == 0 && in_ready == out_ready, "R1 reset idle",
          out_valid, 0);
    rst_n = 1;
    run(2, 0, "R1 pass-through after reset");

    write_cfg(mk(0, 2'b10, 4'd3));
    run(4, 0, "R2 disabled passes all");

    write_cfg(mk(1, 2'b00, 4'd1));
    run(8, 0, "R3 frames from even");

    write_cfg(mk(1, 2'b01, 4'd2));
    run(12, 1, "R4 frames from odd");

    write_cfg(mk(1, 2'b10, 4'd1));
    run(8, 0, "R5 drop even only");

    write_cfg(mk(1, 2'b11, 4'd2));
    run(9, 0, "R6 drop odd only");

    write_cfg(mk(1, 2'b10, 4'd0));
    run(4, 0, "R7 rate zero");
    write_cfg(mk(1, 2'b11, 4'd15));
    run(34, 0, "R7 rate fifteen");

    write_cfg(mk(1, 2'b10, 4'd3));
    run(3, 0, "R10 partial count");
    write_cfg(mk(0, 2'b10, 4'd3));
    run(1, 0, "R10 disabled");
    write_cfg(mk(1, 2'b10, 4'd3));
    run(10, 0, "R10 count restarts");

    write_cfg(8'h80 | mk(1, 2'b00, 4'd1));
    run(6, 0, "R9 reserved bit ignored");

    write_cfg(mk(1, 2'b10, 4'd1));
    send_field(0, 6, 100, "R8 held through mid write", 1, mk(0, 2'b00, 0));
    send_field(1, 6, 100, "R8 new config at next start", 1, mk(1, 2'b11, 4'd2));
    send_field(0, 6, 50, "R8 R9 after write");

    // R11 random traffic under back-pressure
    par = 0;
    for (int k = 0; k < 160; k++) begin
      if ($urandom % 8 == 0) write_cfg(8'($urandom));
      par = ($urandom % 10 == 0) ? par : !par;
      send_field(par, 1 + $urandom % 5, 40 + $urandom % 60, "R11 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule